// File: doc/BRIEF.md
# Flag-setting add/subtract unit

A purely combinational integer arithmetic unit that performs one of four operations on two operands: add, add with carry, subtract and subtract with carry. Alongside the result it produces the four condition flags: negative, zero, carry and signed overflow. The flag values are ready for a status register to capture in the same cycle.

For subtraction the carry flag is an inverted borrow. A set carry means that no borrow occurred. Subtract with carry therefore removes one extra unit when the incoming carry is clear. The operand width and the size of the carry-select blocks are parameters, and the default width is 32 bits.

Top module: `flag_addsub_unit`

## Requirements
- R1: `opCode` selects the operation: 2'b00 add, 2'b01 add with carry, 2'b10 subtract, 2'b11 subtract with carry. For add, `result` is (opA + opB) modulo 2^WIDTH.
- R2: For add, `flagC` is 1 exactly when the unsigned `result` is smaller than `opA`.
- R3: For add with carry and `carryIn` = 1, `result` is opA + opB + 1 modulo 2^WIDTH, and `flagC` is 1 exactly when `result` <= `opA`. With `carryIn` = 0 the operation equals add.
- R4: For subtract, `result` is opA - opB modulo 2^WIDTH, and `flagC` is 1 exactly when `opA` >= `opB` as unsigned numbers.
- R5: For subtract with carry and `carryIn` = 0, `result` is opA - opB - 1 modulo 2^WIDTH, and `flagC` is 1 exactly when `opA` > `opB` as unsigned numbers. With `carryIn` = 1 the operation equals subtract.
- R6: For both add operations, `flagV` is 1 exactly when the true signed sum, including any carry-in unit, falls outside the two's-complement range of WIDTH bits.
- R7: For both subtract operations, `flagV` is 1 exactly when the true signed difference, including any extra unit taken away, falls outside the two's-complement range of WIDTH bits.
- R8: `flagN` equals the most significant bit of `result`. `flagZ` is 1 exactly when every bit of `result` is 0.
- R9: For plain add and plain subtract, `carryIn` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand (minuend for subtract) |
| opB | input | WIDTH | Second operand (subtrahend for subtract) |
| opCode | input | 2 | Operation select |
| carryIn | input | 1 | Current carry flag |
| result | output | WIDTH | Arithmetic result |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry / not-borrow flag |
| flagV | output | 1 | Signed overflow flag |

## Verification
Several flags can change together on a single operation. The hardest cases are a result that wraps to exactly zero, where Z and C rise together, and a sum that crosses the sign boundary, where V and N rise together. A narrow 6-bit instance, built from 2-bit carry-select blocks, is swept over every operand pair, every opcode and both carry-in values, so all of these coincidences occur. Each outcome is compared with an arithmetic model that reads carry and overflow straight from the unsigned comparisons and the signed range. A 32-bit instance receives boundary operands such as 0, 1, the largest positive value, the most negative value and all-ones, followed by random pairs.

// File: rtl/flag_addsub_pkg.sv
package flag_addsub_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_SBC = 2'b11
  } arith_op_e;

  // Strobes from the decoder to the adder datapath
  typedef struct packed {
    logic invB;   // feed the one's complement of operand B
    logic cIn;    // carry into bit 0
  } arith_ctrl_t;

endpackage

// File: rtl/flag_addsub_ctrl.sv
module flag_addsub_ctrl
  import flag_addsub_pkg::*;
(
  input  logic [1:0]  opCode,
  input  logic        carryIn,
  output arith_ctrl_t ctrl
);

  arith_op_e opSel;

  always_comb begin
    opSel = arith_op_e'(opCode);
    ctrl  = '0;
    unique case (opSel)
      OP_ADD: begin ctrl.invB = 1'b0; ctrl.cIn = 1'b0;    end
      OP_ADC: begin ctrl.invB = 1'b0; ctrl.cIn = carryIn; end
      OP_SUB: begin ctrl.invB = 1'b1; ctrl.cIn = 1'b1;    end
      OP_SBC: begin ctrl.invB = 1'b1; ctrl.cIn = carryIn; end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/flag_addsub_dp.sv
module flag_addsub_dp
  import flag_addsub_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int BLOCK_W = 8
)(
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  arith_ctrl_t      ctrl,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             bSign
);

  localparam int NBLK = (WIDTH + BLOCK_W - 1) / BLOCK_W;
  localparam int PADW = NBLK * BLOCK_W;

  logic [WIDTH-1:0] bEff;
  logic [PADW-1:0]  aPad;
  logic [PADW-1:0]  bPad;
  logic [PADW-1:0]  sPad;
  logic [NBLK:0]    blkC;
  logic [PADW:0]    fullSum;

  assign bEff    = ctrl.invB ? ~opB : opB;
  assign bSign   = bEff[WIDTH-1];
  assign aPad    = PADW'(opA);
  assign bPad    = PADW'(bEff);
  assign blkC[0] = ctrl.cIn;

  // Carry-select: each block precomputes both carry-in cases
  for (genvar gi = 0; gi < NBLK; gi++) begin : g_blk
    logic [BLOCK_W:0] sumLo;
    logic [BLOCK_W:0] sumHi;
    assign sumLo = {1'b0, aPad[gi*BLOCK_W +: BLOCK_W]} + {1'b0, bPad[gi*BLOCK_W +: BLOCK_W]};
    assign sumHi = sumLo + (BLOCK_W+1)'(1);
    assign sPad[gi*BLOCK_W +: BLOCK_W] = blkC[gi] ? sumHi[BLOCK_W-1:0] : sumLo[BLOCK_W-1:0];
    assign blkC[gi+1] = blkC[gi] ? sumHi[BLOCK_W] : sumLo[BLOCK_W];
  end

  // Zero padding lets the carry ripple into bit WIDTH of the padded sum
  assign fullSum  = {blkC[NBLK], sPad};
  assign carryOut = fullSum[WIDTH];
  assign sum      = fullSum[WIDTH-1:0];

endmodule

// File: rtl/flag_addsub_flags.sv
module flag_addsub_flags #(
  parameter int WIDTH = 32
)(
  input  logic [WIDTH-1:0] sum,
  input  logic             carryOut,
  input  logic             aSign,
  input  logic             bSign,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV
);

  always_comb begin
    flagN = sum[WIDTH-1];
    flagZ = (sum == '0);
    flagC = carryOut;
    // like-signed adder inputs yielding an unlike-signed sum
    flagV = (aSign == bSign) && (sum[WIDTH-1] != aSign);
  end

endmodule

// File: rtl/flag_addsub_unit.sv
module flag_addsub_unit
  import flag_addsub_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int BLOCK_W = 8
)(
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [1:0]       opCode,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV
);

  arith_ctrl_t      ctrl;
  logic [WIDTH-1:0] sum;
  logic             carryOut;
  logic             bSign;

  flag_addsub_ctrl u_ctrl (
    .opCode  (opCode),
    .carryIn (carryIn),
    .ctrl    (ctrl)
  );

  flag_addsub_dp #(.WIDTH(WIDTH), .BLOCK_W(BLOCK_W)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrl),
    .sum      (sum),
    .carryOut (carryOut),
    .bSign    (bSign)
  );

  flag_addsub_flags #(.WIDTH(WIDTH)) u_flags (
    .sum      (sum),
    .carryOut (carryOut),
    .aSign    (opA[WIDTH-1]),
    .bSign    (bSign),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagC    (flagC),
    .flagV    (flagV)
  );

  assign result = sum;

endmodule

// File: rtl/flag_addsub_chk.sv
module flag_addsub_chk #(
  parameter int WIDTH = 32
)(
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [1:0]       opCode,
  input logic             carryIn,
  input logic [WIDTH-1:0] result,
  input logic             flagC,
  input logic             flagV
);

  logic                   known;
  logic                   extra;
  logic signed [WIDTH+1:0] sA;
  logic signed [WIDTH+1:0] sB;
  logic signed [WIDTH+1:0] kExt;
  logic signed [WIDTH+1:0] exact;
  logic signed [WIDTH+1:0] hiLim;
  logic signed [WIDTH+1:0] loLim;
  logic                   outOfRange;

  always_comb begin
    known = !$isunknown({opA, opB, opCode, carryIn});
    // extra unit: +1 for add-with-carry when set, -1 for subtract-with-carry when clear
    extra = opCode[0] & (opCode[1] ? ~carryIn : carryIn);
    sA    = {{2{opA[WIDTH-1]}}, opA};
    sB    = {{2{opB[WIDTH-1]}}, opB};
    kExt  = {{(WIDTH+1){1'b0}}, extra};
    exact = opCode[1] ? (sA - sB - kExt) : (sA + sB + kExt);
    hiLim = {3'b000, {(WIDTH-1){1'b1}}};
    loLim = {3'b111, {(WIDTH-1){1'b0}}};
    outOfRange = (exact > hiLim) || (exact < loLim);
  end

  always_comb begin
    if (known) begin
      assert_result_value_R1: assert (result == exact[WIDTH-1:0])
        else $error("result mismatch");
      if (opCode == 2'b00 || (opCode == 2'b01 && !carryIn)) begin
        assert_add_carry_R2: assert (flagC == (result < opA))
          else $error("add carry mismatch");
      end
      if (opCode == 2'b01 && carryIn) begin
        assert_adc_carry_R3: assert (flagC == (result <= opA))
          else $error("adc carry mismatch");
      end
      if (opCode == 2'b10 || (opCode == 2'b11 && carryIn)) begin
        assert_sub_carry_R4: assert (flagC == (opA >= opB))
          else $error("sub carry mismatch");
      end
      if (opCode == 2'b11 && !carryIn) begin
        assert_sbc_carry_R5: assert (flagC == (opA > opB))
          else $error("sbc carry mismatch");
      end
      if (!opCode[1]) begin
        assert_add_overflow_R6: assert (flagV == outOfRange)
          else $error("add overflow mismatch");
      end else begin
        assert_sub_overflow_R7: assert (flagV == outOfRange)
          else $error("sub overflow mismatch");
      end
    end
  end

endmodule

bind flag_addsub_unit flag_addsub_chk #(.WIDTH(WIDTH)) u_chk (
  .opA     (opA),
  .opB     (opB),
  .opCode  (opCode),
  .carryIn (carryIn),
  .result  (result),
  .flagC   (flagC),
  .flagV   (flagV)
);

// File: tb/flag_addsub_unit_tb.sv
module flag_addsub_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SW         = 6;
  localparam int SBLK       = 2;
  localparam int WW         = 32;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [SW-1:0] nA, nB, nRes;
  logic [1:0]    nOp;
  logic          nCin, nN, nZ, nC, nV;
  logic [WW-1:0] wA, wB, wRes;
  logic [1:0]    wOp;
  logic          wCin, wN, wZ, wC, wV;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  flag_addsub_unit #(.WIDTH(SW), .BLOCK_W(SBLK)) u_dut (
    .opA(nA), .opB(nB), .opCode(nOp), .carryIn(nCin),
    .result(nRes), .flagN(nN), .flagZ(nZ), .flagC(nC), .flagV(nV)
  );

  flag_addsub_unit u_wide (
    .opA(wA), .opB(wB), .opCode(wOp), .carryIn(wCin),
    .result(wRes), .flagN(wN), .flagZ(wZ), .flagC(wC), .flagV(wV)
  );

  // Reference model built from the requirement text
  function automatic void refCalc(input int w, input longint unsigned a, input longint unsigned b,
                                  input logic [1:0] op, input logic cin,
                                  output longint unsigned r, output logic n, output logic z,
                                  output logic c, output logic v);
    longint unsigned mask = (64'd1 << w) - 64'd1;
    longint half = longint'(64'd1 << (w - 1));
    longint sa = longint'(a);
    longint sb = longint'(b);
    longint ex;
    if (sa >= half) sa = sa - 2 * half;
    if (sb >= half) sb = sb - 2 * half;
    case (op)
      2'b00: begin r = (a + b) & mask; c = (r < a); ex = sa + sb; end
      2'b01: if (cin) begin r = (a + b + 1) & mask; c = (r <= a); ex = sa + sb + 1; end
             else     begin r = (a + b) & mask;     c = (r < a);  ex = sa + sb;     end
      2'b10: begin r = (a - b) & mask; c = (a >= b); ex = sa - sb; end
      default: if (cin) begin r = (a - b) & mask;     c = (a >= b); ex = sa - sb;     end
               else     begin r = (a - b - 1) & mask; c = (a > b);  ex = sa - sb - 1; end
    endcase
    v = (ex >= half) || (ex < -half);
    n = r[w-1];
    z = (r == 0);
  endfunction

  function automatic string tagOf(input logic [1:0] op);
    case (op)
      2'b00:   return "R1 R2 R6 R8 R9";
      2'b01:   return "R3 R6 R8";
      2'b10:   return "R4 R7 R8 R9";
      default: return "R5 R7 R8";
    endcase
  endfunction

  task automatic runVec(input bit wide, input longint unsigned a, input longint unsigned b,
                        input logic [1:0] op, input logic cin);
    longint unsigned er, ar;
    logic en, ez, ec, ev, an, az, ac, av;
    if (wide) begin
      wA = a[WW-1:0]; wB = b[WW-1:0]; wOp = op; wCin = cin;
    end else begin
      nA = a[SW-1:0]; nB = b[SW-1:0]; nOp = op; nCin = cin;
    end
    @(negedge clk);
    refCalc(wide ? WW : SW, a, b, op, cin, er, en, ez, ec, ev);
    if (wide) begin
      ar = longint'(wRes); an = wN; az = wZ; ac = wC; av = wV;
    end else begin
      ar = longint'(nRes); an = nN; az = nZ; ac = nC; av = nV;
    end
    checks++;
    if (ar !== er || an !== en || az !== ez || ac !== ec || av !== ev) begin
      fails++;
      $display("FAIL %s w=%0d op=%0d cin=%0b a=%h b=%h : actual r=%h N%0b Z%0b C%0b V%0b expected r=%h N%0b Z%0b C%0b V%0b",
               tagOf(op), wide ? WW : SW, op, cin, a, b, ar, an, az, ac, av, er, en, ez, ec, ev);
    end
  endtask

  initial begin
    longint unsigned edges [6];
    edges[0] = 64'h0;        edges[1] = 64'h1;
    edges[2] = 64'h7FFFFFFF; edges[3] = 64'h80000000;
    edges[4] = 64'hFFFFFFFF; edges[5] = 64'hFFFFFFFE;
    nA = '0; nB = '0; nOp = 2'b00; nCin = 1'b0;
    wA = '0; wB = '0; wOp = 2'b00; wCin = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // first look after reset: all-zero add gives zero result, Z set (R8)
    runVec(1'b1, 0, 0, 2'b00, 1'b0);
    // exhaustive sweep of the narrow instance: R1..R9, carry-in both ways (R9)
    for (int a = 0; a < (1 << SW); a++)
      for (int b = 0; b < (1 << SW); b++)
        for (int op = 0; op < 4; op++)
          for (int ci = 0; ci < 2; ci++)
            runVec(1'b0, longint'(a), longint'(b), 2'(op), 1'(ci));
    // boundary operands on the full-width instance: sign edge and wrap to zero
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int op = 0; op < 4; op++)
          for (int ci = 0; ci < 2; ci++)
            runVec(1'b1, edges[i], edges[j], 2'(op), 1'(ci));
    // random full-width operands
    for (int k = 0; k < 400; k++)
      runVec(1'b1, longint'($urandom), longint'($urandom), 2'(k % 4), 1'($urandom % 2));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual no completion expected completion within %0d cycles", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule